// File: doc/BRIEF.md
# Register Bus Slave Endpoint

This block is the target end of a simple register-access bus. A requester presents one command at a time on a request channel. Each command carries its opcode, its address and, for writes, the full data word in the same transfer. The block decodes the address onto a small bank of word-wide registers and carries out the access. When the command calls for a reply, the block answers on a separate response channel. Each of the two channels completes a transfer only in a cycle where its valid and accept are both high.

Reads and non-posted writes each produce exactly one response. Posted writes and broadcast writes are fire-and-forget and produce no response. Only one request is in flight at a time: while a response waits for its accept, the request channel is closed. Writes always replace the whole register word, and every access is a single beat.

Top module: `regbus_csr_slave`

## Requirements
- R1: During reset, req_accept and rsp_valid are low. After reset, every register reads as zero.
- R2: A request is taken only in a cycle where req_valid and req_accept are both high. req_accept is high whenever no response is pending.
- R3: Command code 2'b00 is a read. It produces one response with rsp_wack=0 that carries the addressed register's value as it was at the request handshake.
- R4: Command code 2'b01 is a posted write. It replaces the whole 32-bit word of the addressed register and produces no response, and req_accept is still high in the following cycle.
- R5: Command code 2'b10 is a non-posted write. It replaces the register word and produces one response with rsp_wack=1, rsp_rdata=0 and rsp_err=0 for a mapped address.
- R6: Command code 2'b11 is a broadcast write. It updates the addressed register like a posted write and produces no response.
- R7: Address bits [4:2] select one of eight independent registers, and address bits [1:0] are ignored.
- R8: An address with any bit above bit 4 set is unmapped. A read of it returns rsp_rdata=0 with rsp_err=1. A write to it changes no register, and a non-posted write to it is acknowledged with rsp_err=1.
- R9: While rsp_valid is high and rsp_accept is low, rsp_valid, rsp_wack, rsp_err and rsp_rdata hold their values and req_accept stays low. In the cycle after the response handshake, rsp_valid is low and req_accept is high.
- R10: A response becomes visible in the cycle right after the request handshake that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_accept | output | 1 | Slave ready to take a request |
| req_cmd | input | 2 | Opcode: 00 read, 01 posted, 10 non-posted, 11 broadcast |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | DATA_W (32) | Write word, carried with the command |
| rsp_valid | output | 1 | Response present |
| rsp_accept | input | 1 | Requester ready to take the response |
| rsp_wack | output | 1 | 1 = write acknowledge, 0 = read data |
| rsp_err | output | 1 | Access hit an unmapped address |
| rsp_rdata | output | DATA_W (32) | Read word, zero for acknowledges and errors |

## Verification
The hardest case to reach from the ports is a response that sits unaccepted while a new request is already waiting. In that case the slave must keep its response frozen and must not take the waiting command. The bench holds rsp_accept low after a read and raises req_valid with a write to the same register. Over several cycles it checks that the response fields stay frozen and that req_accept stays low. It then releases the response and confirms that the waiting write lands only afterwards, by reading it back. A reset applied in mid-run after registers hold data shows that the bank really clears.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        CMD_READ      = 2'b00,
        CMD_POSTED    = 2'b01,
        CMD_NONPOSTED = 2'b10,
        CMD_BCAST     = 2'b11
    } cmd_e;

endpackage

// File: rtl/regbus_decode.sv
module regbus_decode #(
    parameter int ADDR_W   = 8,
    parameter int BYTE_OFF = 2,
    parameter int IDX_W    = 3,
    parameter int NREGS    = 8
) (
    input  logic [ADDR_W-BYTE_OFF-1:0] word_addr,
    output logic [IDX_W-1:0]           idx,
    output logic                       hit
);
    localparam int HI_W = ADDR_W - BYTE_OFF - IDX_W;

    logic [HI_W-1:0] upper;

    always_comb begin
        idx   = word_addr[IDX_W-1:0];
        upper = word_addr[ADDR_W-BYTE_OFF-1:IDX_W];
        hit   = (upper == '0) && ({1'b0, idx} < (IDX_W+1)'(NREGS));
    end

endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile #(
    parameter int NREGS  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs_d [NREGS];
    logic [DATA_W-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/regbus_csr_slave.sv
module regbus_csr_slave #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = regbus_pkg::WORD_W,
    parameter int NREGS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_accept,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_accept,
    output logic              rsp_wack,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    import regbus_pkg::*;

    localparam int IDX_W    = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int BYTE_OFF = $clog2(DATA_W / 8);

    typedef struct packed {
        logic              acc;
        logic              rvalid;
        logic              wack;
        logic              err;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0]    dec_idx;
    logic                dec_hit;
    logic [DATA_W-1:0]   rf_rdata;
    logic                fire;
    logic                wr_en;
    cmd_e                cmd;
    logic [BYTE_OFF-1:0] unused_byte_bits;

    assign unused_byte_bits = req_addr[BYTE_OFF-1:0];

    regbus_decode #(
        .ADDR_W  (ADDR_W),
        .BYTE_OFF(BYTE_OFF),
        .IDX_W   (IDX_W),
        .NREGS   (NREGS)
    ) u_decode (
        .word_addr(req_addr[ADDR_W-1:BYTE_OFF]),
        .idx      (dec_idx),
        .hit      (dec_hit)
    );

    regbus_regfile #(
        .NREGS (NREGS),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_regfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (dec_idx),
        .wr_data(req_wdata),
        .rd_idx (dec_idx),
        .rd_data(rf_rdata)
    );

    always_comb begin
        cmd   = cmd_e'(req_cmd);
        fire  = req_valid && s_q.acc;
        wr_en = fire && dec_hit && (cmd != CMD_READ);

        s_d = s_q;
        if (s_q.rvalid && rsp_accept) begin
            s_d.rvalid = 1'b0;
        end
        if (fire) begin
            unique case (cmd)
                CMD_READ: begin
                    s_d.rvalid = 1'b1;
                    s_d.wack   = 1'b0;
                    s_d.err    = !dec_hit;
                    s_d.data   = dec_hit ? rf_rdata : '0;
                end
                CMD_NONPOSTED: begin
                    s_d.rvalid = 1'b1;
                    s_d.wack   = 1'b1;
                    s_d.err    = !dec_hit;
                    s_d.data   = '0;
                end
                default: ;
            endcase
        end
        s_d.acc = !s_d.rvalid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_accept = s_q.acc;
    assign rsp_valid  = s_q.rvalid;
    assign rsp_wack   = s_q.wack;
    assign rsp_err    = s_q.err;
    assign rsp_rdata  = s_q.data;

endmodule

// File: rtl/regbus_csr_chk.sv
module regbus_csr_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_accept,
    input logic [1:0]        req_cmd,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_accept,
    input logic              rsp_wack,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic unused_addr;
    assign unused_addr = ^req_addr;

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_accept |=> rsp_valid && $stable(rsp_rdata)
            && $stable(rsp_err) && $stable(rsp_wack));

    // R2
    closed_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_accept);

    // R9
    reopen_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_accept |=> !rsp_valid && req_accept);

    // R3
    read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_accept && req_cmd == 2'b00 |=> rsp_valid && !rsp_wack);

    // R5
    nonposted_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_accept && req_cmd == 2'b10 |=> rsp_valid && rsp_wack
            && rsp_rdata == '0);

    // R4
    posted_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_accept && req_cmd == 2'b01 |=> !rsp_valid && req_accept);

    // R6
    bcast_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_accept && req_cmd == 2'b11 |=> !rsp_valid && req_accept);

    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == '0);

endmodule

bind regbus_csr_slave regbus_csr_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_accept(req_accept),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_accept(rsp_accept),
    .rsp_wack  (rsp_wack),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/test_regbus_csr_slave.sv
module test_regbus_csr_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic [1:0]  cmd;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        rsp;
        logic        wack;
        logic        err;
        logic [31:0] rdata;
    } vec_t;

    // cmd, addr, wdata, response expected, wack, err, rdata
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'h00, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0000}, // R1 reset value
        '{2'b01, 8'h04, 32'hA5A5_0001, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R4
        '{2'b00, 8'h04, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001}, // R3
        '{2'b10, 8'h08, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 32'h0000_0000}, // R5
        '{2'b00, 8'h0B, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h1234_5678}, // R7 low bits ignored
        '{2'b11, 8'h1C, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R6
        '{2'b00, 8'h1C, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R6
        '{2'b00, 8'h20, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'h0000_0000}, // R8 read
        '{2'b01, 8'h24, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R8 write
        '{2'b00, 8'h04, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001}, // R8 untouched
        '{2'b10, 8'h80, 32'h5555_5555, 1'b1, 1'b1, 1'b1, 32'h0000_0000}, // R8 ack err
        '{2'b01, 8'h04, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R4 full word
        '{2'b00, 8'h04, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0000}, // R4
        '{2'b00, 8'h00, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0000}, // R7 independent
        '{2'b00, 8'h18, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0000}  // R7 independent
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_accept;
    logic [1:0]  req_cmd = 2'b00;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_accept = 1'b1;
    logic        rsp_wack;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbus_csr_slave i_regbus_csr_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_accept(req_accept),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_accept(rsp_accept),
        .rsp_wack  (rsp_wack),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one request and return at the falling edge after its handshake.
    task automatic issue(input logic [1:0] c, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = c;
        req_addr  = a;
        req_wdata = d;
        while (!req_accept) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        check("R1 accept in reset", {31'b0, req_accept}, 32'd0);
        check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 accept when idle", {31'b0, req_accept}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].cmd, VECS[i].addr, VECS[i].wdata);
            // R10: response appears the cycle after the handshake
            check($sformatf("R10 vec%0d rsp_valid", i), {31'b0, rsp_valid}, {31'b0, VECS[i].rsp});
            if (VECS[i].rsp) begin
                check($sformatf("R3 vec%0d wack", i), {31'b0, rsp_wack}, {31'b0, VECS[i].wack});
                check($sformatf("R8 vec%0d err", i), {31'b0, rsp_err}, {31'b0, VECS[i].err});
                check($sformatf("R3 vec%0d rdata", i), rsp_rdata, VECS[i].rdata);
                check($sformatf("R2 vec%0d accept closed", i), {31'b0, req_accept}, 32'd0);
                @(negedge clk);
                check($sformatf("R9 vec%0d released", i), {30'b0, rsp_valid, req_accept}, 32'd1);
            end else begin
                check($sformatf("R4 vec%0d accept open", i), {31'b0, req_accept}, 32'd1);
            end
        end

        // R9: stalled response with a waiting request
        rsp_accept = 1'b0;
        issue(2'b00, 8'h1C, 32'h0);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = 2'b01;
        req_addr  = 8'h1C;
        req_wdata = 32'h1111_1111;
        for (int k = 0; k < 3; k++) begin
            check("R9 stall valid", {31'b0, rsp_valid}, 32'd1);
            check("R9 stall rdata", rsp_rdata, 32'hDEAD_BEEF);
            check("R9 stall accept low", {31'b0, req_accept}, 32'd0);
            @(negedge clk);
        end
        rsp_accept = 1'b1;
        @(negedge clk);
        check("R9 after release", {30'b0, rsp_valid, req_accept}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        issue(2'b00, 8'h1C, 32'h0);
        check("R2 waiting write landed", rsp_rdata, 32'h1111_1111);
        @(negedge clk);

        // R1: reset in mid-run clears the bank
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 accept in mid reset", {30'b0, rsp_valid, req_accept}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(2'b00, 8'h1C, 32'h0);
        check("R1 register cleared", rsp_rdata, 32'h0);
        @(negedge clk);

        // R7: byte-offset bits ignored on write
        issue(2'b10, 8'h17, 32'hCAFE_0005);
        @(negedge clk);
        issue(2'b00, 8'h14, 32'h0);
        check("R7 write with low bits", rsp_rdata, 32'hCAFE_0005);
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule